// File: doc/BRIEF.md
# Glitchless Output Enable Gate

This block sits between a set of divided clocks and the output drivers of a clock generator. It has eight clock lanes and three active-low enable pins. A mapping vector connects each pin to any subset of lanes. A lane runs only while every pin connected to it is low. A lane with no pin connected to it always runs.

The enable pins are asynchronous. A two-flop stage brings them into the reference clock domain. Each lane then latches its new enable decision only during a reference cycle in which its own divided clock is low. As a result, a high pulse already in progress always completes. After an enable, the first pulse to appear is a whole one.

A stopped lane drives the idle state chosen for it. The choices are a constant low, a constant high, or high impedance. High impedance is modelled as a data value plus a drive-enable output.

Top module: `clk_oe_gate`

## Requirements
- R1: Lane j is enabled when no pin i with `link_map[i*8+j]`=1 has `en_n[i]`=1. Pins that are not linked to a lane have no effect on it.
- R2: A lane with no linked pin is always enabled, whatever the pin levels.
- R3: When several pins are linked to one lane, a single linked pin held high disables the lane, even if the other linked pins are low.
- R4: An enabled lane drives `clk_out[j]` equal to `div_clk[j]` and holds `clk_oe[j]`=1.
- R5: A lane's enable state changes only at a clock edge where `div_clk[j]` was sampled low. A high pulse in progress when the lane is disabled therefore runs to its end.
- R6: Once enabled, a lane stays at its idle level through any high phase that was already under way. Its first output pulse begins with the next rising edge of `div_clk[j]` and lasts the full high phase.
- R7: A disabled lane selects its idle state with `idle_mode[2j+1:2j]`:
  - 00 drives low (`clk_oe`=1, `clk_out`=0).
  - 01 drives high (`clk_oe`=1, `clk_out`=1).
  - 10 or 11 is high impedance (`clk_oe`=0, `clk_out`=0).
- R8: A pin change that enables a lane, made while that lane's clock is low, changes the output after the third rising edge of `clk` and not before.
- R9: While `rst_n` is low, every lane is disabled and drives its idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the divided clocks are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_clk | input | 8 | Divided clocks, one per lane |
| en_n | input | 3 | Active-low enable pins, asynchronous |
| link_map | input | 24 | Bit i*8+j links pin i to lane j |
| idle_mode | input | 16 | Two bits per lane selecting the idle state |
| clk_out | output | 8 | Gated clock or idle level per lane |
| clk_oe | output | 8 | Output driver enable per lane (0 = high impedance) |

## Verification
The assertions assume the following about the inputs:
- Each divided clock changes only just after a reference clock edge, so it holds one level for a whole reference cycle.
- The link map and idle modes are quasi-static. They change only when the user deliberately reconfigures the block.

The enable pins themselves may change at any time. The bench keeps to these assumptions in two ways. It builds the divided clocks from counters clocked by the reference clock. It changes the map, modes and pins only at falling edges, and then waits for the synchroniser and each lane's low phase to settle before it compares the outputs.

// File: rtl/oeg_pkg.sv
package oeg_pkg;
  // Idle state encoding per lane; both upper codes mean high impedance.
  typedef enum logic [1:0] {
    IDLE_LOW    = 2'b00,
    IDLE_HIGH   = 2'b01,
    IDLE_HIZ    = 2'b10,
    IDLE_HIZ_B  = 2'b11
  } idle_e;
endpackage

// File: rtl/oeg_sync.sv
module oeg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  // Reset to all ones: the pins read as "disable" until they are sampled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/oeg_route.sv
module oeg_route #(
  parameter int N_PIN = 3,
  parameter int N_OUT = 8
) (
  input  logic [N_PIN-1:0]       pin_hi_i,
  input  logic [N_PIN*N_OUT-1:0] link_i,
  output logic [N_OUT-1:0]       want_en_o
);
  // A lane wants to run unless some linked pin requests disable.
  always_comb begin
    for (int j = 0; j < N_OUT; j++) begin
      want_en_o[j] = 1'b1;
      for (int i = 0; i < N_PIN; i++) begin
        if (link_i[i*N_OUT+j] && pin_hi_i[i]) want_en_o[j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/oeg_lane.sv
module oeg_lane
  import oeg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       div_i,
  input  logic       want_en_i,
  input  logic [1:0] mode_i,
  output logic       gate_o,
  output logic       out_o,
  output logic       oe_o
);
  logic  gate_q, gate_d, upd_en;
  idle_e mode;

  assign mode   = idle_e'(mode_i);
  // Decision is taken only while the divided clock is low.
  assign upd_en = ~div_i;

  always_comb begin
    gate_d = gate_q;
    if (upd_en) gate_d = want_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  always_comb begin
    if (gate_q) begin
      out_o = div_i;
      oe_o  = 1'b1;
    end else begin
      unique case (mode)
        IDLE_LOW:  begin out_o = 1'b0; oe_o = 1'b1; end
        IDLE_HIGH: begin out_o = 1'b1; oe_o = 1'b1; end
        default:   begin out_o = 1'b0; oe_o = 1'b0; end
      endcase
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/clk_oe_gate.sv
module clk_oe_gate #(
  parameter int N_OUT  = 8,
  parameter int N_PIN  = 3,
  parameter int STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_OUT-1:0]       div_clk,
  input  logic [N_PIN-1:0]       en_n,
  input  logic [N_PIN*N_OUT-1:0] link_map,
  input  logic [2*N_OUT-1:0]     idle_mode,
  output logic [N_OUT-1:0]       clk_out,
  output logic [N_OUT-1:0]       clk_oe
);
  localparam int MAP_W = N_PIN * N_OUT;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [N_PIN-1:0] pin_hi;
  logic [N_OUT-1:0] want_en;
  logic [N_OUT-1:0] gate_vec;

  // Asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  oeg_sync #(.W(N_PIN), .STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (en_n),
    .sync_o  (pin_hi)
  );

  oeg_route #(.N_PIN(N_PIN), .N_OUT(N_OUT)) u_route (
    .pin_hi_i  (pin_hi),
    .link_i    (link_map[MAP_W-1:0]),
    .want_en_o (want_en)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_lane
    oeg_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .div_i     (div_clk[j]),
      .want_en_i (want_en[j]),
      .mode_i    (idle_mode[2*j +: 2]),
      .gate_o    (gate_vec[j]),
      .out_o     (clk_out[j]),
      .oe_o      (clk_oe[j])
    );
  end
endmodule

// File: rtl/oeg_checker.sv
module oeg_checker #(
  parameter int N_OUT = 8,
  parameter int N_PIN = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_OUT-1:0]       div_clk,
  input logic [N_PIN-1:0]       en_n,
  input logic [N_PIN*N_OUT-1:0] link_map,
  input logic [2*N_OUT-1:0]     idle_mode,
  input logic [N_OUT-1:0]       clk_out,
  input logic [N_OUT-1:0]       clk_oe,
  input logic [N_OUT-1:0]       gate_vec
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_chk
    // R5: the lane state moves only after a low sample of its clock
    p_gate_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_vec[j]) |-> !$past(div_clk[j]));

    // R4: a running lane passes its clock and drives
    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gate_vec[j] |-> (clk_out[j] == div_clk[j]) && clk_oe[j]);

    // R7: a stopped lane shows its selected idle state
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_vec[j] |-> (clk_oe[j] == !idle_mode[2*j+1]) &&
                       (clk_out[j] == (idle_mode[2*j +: 2] == 2'b01)));

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
      // R3: one linked pin held high stops the lane at its low phase
      p_dominance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n[i] && $past(en_n[i]) && $past(en_n[i], 2) &&
         link_map[i*N_OUT+j] && !div_clk[j]) |=> !gate_vec[j]);
    end
  end
endmodule

bind clk_oe_gate oeg_checker #(.N_OUT(N_OUT), .N_PIN(N_PIN)) u_oeg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_clk   (div_clk),
  .en_n      (en_n),
  .link_map  (link_map),
  .idle_mode (idle_mode),
  .clk_out   (clk_out),
  .clk_oe    (clk_oe),
  .gate_vec  (gate_vec)
);

// File: tb/tb_clk_oe_gate.sv
`timescale 1ns/1ps
module tb_clk_oe_gate;
  localparam int N_OUT = 8;
  localparam int N_PIN = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_OUT-1:0]  div_clk = '0;
  logic [N_PIN-1:0]  en_n = '0;
  logic [23:0]       link_map = '0;
  logic [15:0]       idle_mode = '0;
  logic [N_OUT-1:0]  clk_out, clk_oe;
  int                div_cnt [N_OUT];
  int                n_checks = 0;
  int                n_fail = 0;
  logic              last7;

  always #10 clk = ~clk;

  clk_oe_gate dut (
    .clk(clk), .rst_n(rst_n), .div_clk(div_clk), .en_n(en_n),
    .link_map(link_map), .idle_mode(idle_mode),
    .clk_out(clk_out), .clk_oe(clk_oe)
  );

  // Lane j has a half period of j+1 reference cycles.
  initial for (int j = 0; j < N_OUT; j++) div_cnt[j] = 0;
  always @(posedge clk) begin
    for (int j = 0; j < N_OUT; j++) begin
      if (div_cnt[j] == j) begin
        div_cnt[j] <= 0;
        div_clk[j] <= ~div_clk[j];
      end else begin
        div_cnt[j] <= div_cnt[j] + 1;
      end
    end
  end

  // {link_map, idle_mode, en_n}
  localparam logic [42:0] VEC [6] = '{
    {24'h000000, 16'h0000, 3'b111},
    {24'h36C029, 16'h5555, 3'b001},
    {24'h36C029, 16'hE4E4, 3'b100},
    {24'h36C029, 16'h5555, 3'b000},
    {24'hFFFFFF, 16'hAAAA, 3'b010},
    {24'hFF0000, 16'h5555, 3'b011}
  };
  localparam string VTAG [6] = '{"R2", "R1 R3", "R3 R7", "R4", "R7", "R1"};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expect_vec(logic [23:0] m, logic [15:0] md,
                                             logic [2:0] e, logic [7:0] d);
    logic [7:0] o, oe;
    for (int j = 0; j < 8; j++) begin
      logic run;
      run = 1'b1;
      for (int i = 0; i < 3; i++) if (m[i*8+j] && e[i]) run = 1'b0;
      if (run) begin o[j] = d[j]; oe[j] = 1'b1; end
      else begin
        o[j]  = (md[2*j +: 2] == 2'b01);
        oe[j] = ~md[2*j+1];
      end
    end
    return {oe, o};
  endfunction

  task automatic wait_rise7();
    do begin
      last7 = div_clk[7];
      @(negedge clk);
    end while (!(div_clk[7] && !last7));
  endtask

  task automatic wait_fall7();
    do begin
      last7 = div_clk[7];
      @(negedge clk);
    end while (!(!div_clk[7] && last7));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    idle_mode = 16'h5555;
    en_n = 3'b000;
    repeat (4) @(negedge clk);
    chk("R9 idle high in reset", {clk_oe, clk_out}, 16'hFFFF);
    idle_mode = 16'hAAAA;
    @(negedge clk);
    chk("R9 hi-z in reset", {clk_oe, clk_out}, 16'h0000);
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      {link_map, idle_mode, en_n} = VEC[v];
      repeat (24) @(negedge clk);
      for (int k = 0; k < 16; k++) begin
        chk(VTAG[v], {clk_oe, clk_out},
            expect_vec(link_map, idle_mode, en_n, div_clk));
        @(negedge clk);
      end
    end

    // R5: disable during a high phase lets the pulse finish
    link_map = 24'h000080; idle_mode = 16'h0000; en_n = 3'b000;
    repeat (30) @(negedge clk);
    wait_rise7();
    en_n = 3'b001;
    while (div_clk[7]) begin
      chk("R5 pulse completes", clk_out[7], 1'b1);
      @(negedge clk);
    end
    wait_rise7();
    chk("R5 disabled after boundary", clk_out[7], 1'b0);

    // R6: enable during a high phase waits for the next rising edge
    en_n = 3'b000;
    while (div_clk[7]) begin
      chk("R6 no partial pulse", clk_out[7], 1'b0);
      @(negedge clk);
    end
    wait_rise7();
    for (int k = 0; k < 8; k++) begin
      chk("R6 first pulse full", clk_out[7], 1'b1);
      @(negedge clk);
    end

    // R8: synchroniser latency
    idle_mode = 16'h4000; en_n = 3'b001;
    repeat (30) @(negedge clk);
    wait_fall7();
    en_n = 3'b000;
    @(negedge clk);
    chk("R8 one edge", clk_out[7], 1'b1);
    @(negedge clk);
    chk("R8 two edges", clk_out[7], 1'b1);
    @(negedge clk);
    chk("R8 three edges", clk_out[7], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule